// File: doc/BRIEF.md
# Byte-Lane Controller Command Register Block

This block is the memory-mapped register face of a storage bus controller. A host reaches it through a single-cycle valid/write bus carrying a byte address and a data byte. Writes and reads at the same address reach two separate register sets. The write side keeps the programmed transfer length and takes command bytes. The read side presents status, interrupt cause, sequence step and a fixed chip identifier.

A byte written to the command index is latched and executed in the next cycle. The state machine moves from `ST_IDLE` to `ST_EXEC` on every command write. In `ST_EXEC` the decoded command updates the status, interrupt and sequence registers at the closing edge. Select commands pulse `sel_start` to the command decoder. Transfer commands pulse `xfer_start` and drive `xfer_len` to the DMA engine. The state machine returns to `ST_IDLE` unless another command write arrives, in which case it stays in `ST_EXEC`. A level interrupt request is raised by every command that ends a bus action. Reading the interrupt register drops the request.

Top module: `bclr_ctrl`

## Requirements
- R1: The register index is `bus_addr[5:2]`. Address bits 1:0 and bits above bit 5 have no effect on which register is reached.
- R2: Write-side and read-side registers are separate. A bus write never changes the value read back at any index. Writes to index 0 (low byte) and index 1 (high byte) set the transfer length used by command 0x10.
- R3: After reset, every read-side register reads 0x00 except the identifier at index 14, which reads 0x04. `irq` is low.
- R4: A command is the low 7 bits of a byte written to index 3, so bit 7 of the byte is ignored. Its strobes are high during the single cycle after the write cycle. Its register updates are visible from the edge that ends that cycle.
- R5: Command 0x01 sets sequence (index 6) to 0x00 and interrupt (index 5) to 0x08. It leaves status (index 4) and `irq` unchanged.
- R6: Command 0x02 returns all read-side registers to their reset values, including identifier 0x04, and drops `irq`.
- R7: Command 0x11 pulses `xfer_start` with `xfer_len` = 2. It then sets status 0x93, interrupt 0x18, sequence 0x04 and raises `irq`.
- R8: Command 0x12 pulses `xfer_start` with `xfer_len` = 2. It then sets status 0x93, interrupt 0x20, sequence 0x00 and raises `irq`.
- R9: Command 0x10 pulses `xfer_start` with `xfer_len` = {index 1, index 0}. It then sets status 0x93, interrupt 0x10, sequence 0x00 and raises `irq`.
- R10: Commands 0x42 and 0x43 pulse `sel_start`. They then set status 0x91, interrupt 0x18, sequence 0x04 and raise `irq`. `sel_start` and `xfer_start` are never high together.
- R11: Command codes 0x00, 0x03, 0x1A and every other code not listed above change no register, no strobe and no `irq`.
- R12: Reads are combinational with zero wait states. Index 15 (at or above `NREG`) reads 0x00.
- R13: A read of index 5 clears `irq` at the next edge. If a command raising `irq` executes in that same cycle, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| irq | output | 1 | Level interrupt request |
| sel_start | output | 1 | Select start strobe to the decoder |
| xfer_start | output | 1 | Transfer start strobe to the DMA engine |
| xfer_len | output | 16 | Byte count valid with `xfer_start` |

## Verification
A host read of the interrupt register, which clears `irq`, can land in the very cycle that a previously written command executes in `ST_EXEC` and sets `irq`. The bench provokes this by issuing a read of index 5 on the bus in the cycle right after a command write. It then judges two results. The read returns the interrupt value from before the command. `irq` remains high after the edge, with the interrupt register holding the new value.

// File: rtl/bclr_pkg.sv
package bclr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } state_t;

    typedef struct packed {
        logic       upd_stat;
        logic       upd_is;
        logic       clr_all;
        logic       set_irq;
        logic       sel;
        logic       xfer;
        logic       len_fixed;
        logic [7:0] stat;
        logic [7:0] intr;
        logic [7:0] seq;
    } effect_t;

    localparam int IDX_W       = 4;
    localparam int IDX_LEN_LO  = 0;
    localparam int IDX_LEN_HI  = 1;
    localparam int IDX_CMD     = 3;
    localparam int IDX_STAT    = 4;
    localparam int IDX_INTR    = 5;
    localparam int IDX_SEQ     = 6;
    localparam int IDX_ID      = 14;
    localparam logic [7:0] ID_VAL = 8'h04;
    localparam logic [15:0] FIXED_LEN = 16'd2;

endpackage

// File: rtl/bclr_cmd_decode.sv
module bclr_cmd_decode
    import bclr_pkg::*;
(
    input  logic [6:0] code,
    output effect_t    eff
);
    always_comb begin
        eff = '0;
        case (code)
            7'h01: begin
                eff.upd_is = 1'b1;
                eff.intr   = 8'h08;
                eff.seq    = 8'h00;
            end
            7'h02: eff.clr_all = 1'b1;
            7'h10: begin
                eff.upd_stat = 1'b1; eff.upd_is = 1'b1; eff.set_irq = 1'b1;
                eff.xfer     = 1'b1;
                eff.stat = 8'h93; eff.intr = 8'h10; eff.seq = 8'h00;
            end
            7'h11: begin
                eff.upd_stat = 1'b1; eff.upd_is = 1'b1; eff.set_irq = 1'b1;
                eff.xfer     = 1'b1; eff.len_fixed = 1'b1;
                eff.stat = 8'h93; eff.intr = 8'h18; eff.seq = 8'h04;
            end
            7'h12: begin
                eff.upd_stat = 1'b1; eff.upd_is = 1'b1; eff.set_irq = 1'b1;
                eff.xfer     = 1'b1; eff.len_fixed = 1'b1;
                eff.stat = 8'h93; eff.intr = 8'h20; eff.seq = 8'h00;
            end
            7'h42, 7'h43: begin
                eff.upd_stat = 1'b1; eff.upd_is = 1'b1; eff.set_irq = 1'b1;
                eff.sel      = 1'b1;
                eff.stat = 8'h91; eff.intr = 8'h18; eff.seq = 8'h04;
            end
            default: eff = '0;
        endcase
    end
endmodule

// File: rtl/bclr_regfile.sv
module bclr_regfile
    import bclr_pkg::*;
#(
    parameter int NREG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             clr_all,
    input  logic             upd_stat,
    input  logic             upd_is,
    input  logic [7:0]       stat_val,
    input  logic [7:0]       intr_val,
    input  logic [7:0]       seq_val,
    output logic [15:0]      len_w
);
    logic [7:0] rr [NREG];
    logic [7:0] len_lo, len_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rr[i] <= (i == IDX_ID) ? ID_VAL : 8'h00;
            len_lo <= 8'h00;
            len_hi <= 8'h00;
        end else begin
            if (clr_all) begin
                for (int i = 0; i < NREG; i++) rr[i] <= (i == IDX_ID) ? ID_VAL : 8'h00;
            end else begin
                if (upd_stat) rr[IDX_STAT] <= stat_val;
                if (upd_is) begin
                    rr[IDX_INTR] <= intr_val;
                    rr[IDX_SEQ]  <= seq_val;
                end
            end
            if (wr_en && wr_idx == IDX_W'(IDX_LEN_LO)) len_lo <= wr_data;
            if (wr_en && wr_idx == IDX_W'(IDX_LEN_HI)) len_hi <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = rr[i];
    end

    assign len_w = {len_hi, len_lo};
endmodule

// File: rtl/bclr_ctrl.sv
module bclr_ctrl
    import bclr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NREG   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              sel_start,
    output logic              xfer_start,
    output logic [15:0]       xfer_len
);
    logic [IDX_W-1:0] idx;
    logic             unused_addr;
    assign idx         = bus_addr[5:2];
    assign unused_addr = ^{bus_addr[ADDR_W-1:6], bus_addr[1:0]};

    state_t     state, state_nx;
    logic [6:0] cmd_q;
    effect_t    eff;
    logic       cmd_wr, exec, rd_intr;
    logic [15:0] len_w;

    assign cmd_wr  = bus_valid && bus_write && idx == IDX_W'(IDX_CMD);
    assign rd_intr = bus_valid && !bus_write && idx == IDX_W'(IDX_INTR);
    assign exec    = (state == ST_EXEC);

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = cmd_wr ? ST_EXEC : ST_IDLE;
            ST_EXEC: state_nx = cmd_wr ? ST_EXEC : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd_q <= 7'h00;
        end else begin
            state <= state_nx;
            if (cmd_wr) cmd_q <= bus_wdata[6:0];
        end
    end

    bclr_cmd_decode u_dec (.code(cmd_q), .eff(eff));

    always_comb begin
        sel_start  = 1'b0;
        xfer_start = 1'b0;
        xfer_len   = 16'h0000;
        unique case (state)
            ST_IDLE: ;
            ST_EXEC: begin
                sel_start  = eff.sel;
                xfer_start = eff.xfer;
                if (eff.xfer) xfer_len = eff.len_fixed ? FIXED_LEN : len_w;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    irq <= 1'b0;
        else if (exec && eff.clr_all)  irq <= 1'b0;
        else if (exec && eff.set_irq)  irq <= 1'b1;
        else if (rd_intr)              irq <= 1'b0;
    end

    bclr_regfile #(.NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_valid && bus_write),
        .wr_idx   (idx),
        .wr_data  (bus_wdata),
        .rd_idx   (idx),
        .rd_data  (bus_rdata),
        .clr_all  (exec && eff.clr_all),
        .upd_stat (exec && eff.upd_stat),
        .upd_is   (exec && eff.upd_is),
        .stat_val (eff.stat),
        .intr_val (eff.intr),
        .seq_val  (eff.seq),
        .len_w    (len_w)
    );
endmodule

// File: rtl/bclr_ctrl_chk.sv
module bclr_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int NREG   = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              irq,
    input logic              sel_start,
    input logic              xfer_start,
    input logic [15:0]       xfer_len
);
    logic cmd_wr;
    assign cmd_wr = bus_valid && bus_write && bus_addr[5:2] == 4'd3;

    a_r4_xfer_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(cmd_wr));

    a_r10_sel_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start |-> $past(cmd_wr && (bus_wdata[6:0] == 7'h42 || bus_wdata[6:0] == 7'h43)));

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_start, xfer_start}));

    a_r7_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && $past(bus_wdata[6:0] == 7'h11 || bus_wdata[6:0] == 7'h12)) |-> xfer_len == 16'd2);

    a_r13_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sel_start || xfer_start));

    a_r12_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && 32'(bus_addr[5:2]) >= NREG) |-> bus_rdata == 8'h00);
endmodule

bind bclr_ctrl bclr_ctrl_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sel_start(sel_start), .xfer_start(xfer_start), .xfer_len(xfer_len)
);

// File: tb/bclr_ctrl_test.sv
module bclr_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic irq, sel_start, xfer_start;
    logic [15:0] xfer_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    bclr_ctrl #(.ADDR_W(8), .NREG(15)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sel_start(sel_start), .xfer_start(xfer_start), .xfer_len(xfer_len)
    );

    int checks = 0, fails = 0;
    logic [7:0] m_r [16];
    logic [7:0] m_lo, m_hi;
    logic       m_irq;
    logic       e_sel, e_xfer;
    logic [15:0] e_len;

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) m_r[i] = 8'h00;
        m_r[14] = 8'h04;
        m_irq = 1'b0;
    endfunction

    function automatic void model_cmd(input logic [6:0] c);
        e_sel = 1'b0; e_xfer = 1'b0; e_len = 16'h0;
        case (c)
            7'h01: begin m_r[5] = 8'h08; m_r[6] = 8'h00; end
            7'h02: model_reset();
            7'h10: begin m_r[4] = 8'h93; m_r[5] = 8'h10; m_r[6] = 8'h00; m_irq = 1'b1;
                         e_xfer = 1'b1; e_len = {m_hi, m_lo}; end
            7'h11: begin m_r[4] = 8'h93; m_r[5] = 8'h18; m_r[6] = 8'h04; m_irq = 1'b1;
                         e_xfer = 1'b1; e_len = 16'd2; end
            7'h12: begin m_r[4] = 8'h93; m_r[5] = 8'h20; m_r[6] = 8'h00; m_irq = 1'b1;
                         e_xfer = 1'b1; e_len = 16'd2; end
            7'h42, 7'h43: begin m_r[4] = 8'h91; m_r[5] = 8'h18; m_r[6] = 8'h04; m_irq = 1'b1;
                         e_sel = 1'b1; end
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] mk_addr(input int idx);
        return {$urandom_range(0, 3) == 0 ? 2'b00 : 2'($urandom), 4'(idx), 2'($urandom)};
    endfunction

    task automatic bus_wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = mk_addr(idx); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (idx == 0) m_lo = d;
        if (idx == 1) m_hi = d;
    endtask

    task automatic bus_rd(input int idx, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = mk_addr(idx);
        #1 chk(16'(bus_rdata), 16'(m_r[idx]), $sformatf("%s read idx %0d", tag, idx));
        @(negedge clk);
        bus_valid = 1'b0;
        if (idx == 5) m_irq = 1'b0;
        chk(16'(irq), 16'(m_irq), {tag, " irq after read"});
    endtask

    task automatic issue_cmd(input logic [7:0] code, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = mk_addr(3); bus_wdata = code;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        model_cmd(code[6:0]);
        chk(16'(xfer_start), 16'(e_xfer), {tag, " R4 xfer_start"});
        chk(16'(sel_start), 16'(e_sel), {tag, " R10 sel_start"});
        if (e_xfer) chk(xfer_len, e_len, {tag, " xfer_len"});
        @(negedge clk);
        chk(16'(xfer_start | sel_start), 16'h0, {tag, " R4 strobe one cycle"});
        chk(16'(irq), 16'(m_irq), {tag, " irq"});
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) if (i != 5) bus_rd(i, tag);
    endtask

    bit done = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_lo = 8'h00; m_hi = 8'h00;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state, R12 index 15 reads zero
        chk(16'(irq), 16'h0, "R3 irq at reset");
        check_all("R3 R12");

        // R5 flush keeps status
        issue_cmd(8'h11, "R7");
        check_all("R7");
        issue_cmd(8'h01, "R5");
        check_all("R5");
        bus_rd(5, "R13 R5");

        // R8, R9 with programmed length; R1 aliases through mk_addr
        issue_cmd(8'h12, "R8");
        check_all("R8");
        bus_wr(0, 8'h34); bus_wr(1, 8'hA2);
        issue_cmd(8'h10, "R9");
        // R2: writes to read-side indices do not change readback
        bus_wr(4, 8'h5A); bus_wr(14, 8'hFF);
        check_all("R2");
        issue_cmd(8'h43, "R10");
        issue_cmd(8'hC2, "R4 R10 bit7");
        check_all("R10");
        // R11 no-op codes
        issue_cmd(8'h00, "R11"); issue_cmd(8'h03, "R11"); issue_cmd(8'h1A, "R11");
        issue_cmd(8'h7F, "R11");
        check_all("R11");
        // R6 chip reset
        issue_cmd(8'h02, "R6");
        check_all("R6");

        // R13 concurrency: read of interrupt register while command executes
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = mk_addr(3); bus_wdata = 8'h11;
        @(negedge clk);
        bus_write = 1'b0; bus_addr = mk_addr(5);
        #1 chk(16'(bus_rdata), 16'(m_r[5]), "R13 read returns old interrupt");
        chk(16'(xfer_start), 16'h1, "R13 xfer_start during read");
        model_cmd(7'h11);
        @(negedge clk);
        bus_valid = 1'b0;
        chk(16'(irq), 16'h1, "R13 set wins over read clear");
        bus_rd(5, "R13");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                int ix;
                ix = $urandom_range(0, 15);
                if (ix == 3) ix = 0;
                bus_wr(ix, 8'($urandom));
            end else if (op < 6) begin
                logic [7:0] pick [10];
                pick = '{8'h01, 8'h02, 8'h10, 8'h11, 8'h12, 8'h42, 8'h43, 8'h00, 8'h1A, 8'($urandom)};
                issue_cmd(pick[$urandom_range(0, 9)] ^ {1'($urandom), 7'h0}, "R4 random");
            end else begin
                bus_rd($urandom_range(0, 15), "R12 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule